// File: doc/BRIEF.md
# AXI Address-Channel Protection Filter

This block sits between one AXI master and one memory on the write-address and read-address channels. It never touches the data or response channels. Software programs up to eight address windows through a small register port. Windows sit on 128-byte boundaries, and each has its own enable. Every burst that the master issues is expanded into the byte range it will touch: its span, worked out from the start address, the beat count, the beat size and the burst type. The burst is allowed through only if a single enabled window contains the whole span.

A burst that fails the check is not dropped and gets no error response. It still goes downstream, but as a FIXED burst aimed at a constant fault address, so the memory sees a harmless access and the channel handshakes stay intact. The ID, length, size, lock, cache and protection fields ride through untouched in both cases.

Each address channel is a valid/ready stream with one register stage. A beat is taken when `valid` and `ready` are both high at a clock edge, and it appears downstream on the next cycle. Upstream `ready` is high whenever the output register is empty or the downstream side is taking its beat. A stalled output therefore holds its payload stable and pushes the stall back to the master. Each channel also has a one-cycle violation pulse and a sticky flag. These status pins are plain levels.

Top module: `axi_addr_guard`

## Requirements
- R1: Register port (write on `cfg_we`, read combinational on `cfg_rdata`). Index k (0..7) holds the start of window k, and its low 7 bits always read 0. Index 8+k holds the end of window k, and its low 7 bits always read 1. Index 16 holds the window enables in bits 7:0. Index 17 is status: bit 0 is the write sticky flag and bit 1 is the read sticky flag.
- R2: A legal burst leaves the output register with the same address and burst type it entered with. Its ID, LEN, SIZE, LOCK, CACHE and PROT are also unchanged.
- R3: A violating burst is forwarded with burst type FIXED (encoding 0) and address `FAULT_ADDR`. All other fields are unchanged.
- R4: An INCR burst (encoding 1) spans addr to addr+(LEN+1)*2^SIZE-1. It is legal only when one enabled window holds all of that span, so a partial overlap is a violation.
- R5: A WRAP burst (encoding 2) spans the (LEN+1)*2^SIZE-byte block, aligned to its own size, that contains addr. A WRAP burst with LEN not in {1,3,7,15} is a violation, and so is a burst with type encoding 3.
- R6: A FIXED burst spans only addr to addr+2^SIZE-1, whatever its LEN.
- R7: A disabled window never matches. A window whose end lies below its start never matches. With no window enabled, every burst is a violation.
- R8: A beat accepted at one edge is presented on the output in the following cycle. While the output is valid and not ready, the output holds stable and upstream ready is low.
- R9: A violation raises the channel's violation pulse for one cycle, in the same cycle the rewritten beat first appears on the output. The channel's sticky flag is set in the next cycle. Writing 1 to a status bit clears that flag, and a new violation wins over a clear in the same cycle.
- R10: The write and read channels are checked and flagged independently. A violation on one channel does not alter the other channel's beat or flags.
- R11: A span whose last byte would pass the top of the address space is a violation, while a span ending exactly on the last address is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register index |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Register read data (combinational) |
| s_aw_valid | input | 1 | Write address from master valid |
| s_aw_ready | output | 1 | Write address ready to master |
| s_aw_id | input | ID_W | Write ID |
| s_aw_addr | input | ADDR_W | Write start address |
| s_aw_len | input | 4 | Write beats minus one |
| s_aw_size | input | 3 | Write log2 bytes per beat |
| s_aw_burst | input | 2 | Write burst type |
| s_aw_lock | input | 1 | Write lock |
| s_aw_cache | input | 4 | Write cache attributes |
| s_aw_prot | input | 3 | Write protection attributes |
| m_aw_valid | output | 1 | Write address to memory valid |
| m_aw_ready | input | 1 | Write address ready from memory |
| m_aw_id | output | ID_W | Forwarded write ID |
| m_aw_addr | output | ADDR_W | Forwarded or fault write address |
| m_aw_len | output | 4 | Forwarded write length |
| m_aw_size | output | 3 | Forwarded write size |
| m_aw_burst | output | 2 | Forwarded or forced write burst type |
| m_aw_lock | output | 1 | Forwarded write lock |
| m_aw_cache | output | 4 | Forwarded write cache |
| m_aw_prot | output | 3 | Forwarded write protection |
| s_ar_valid | input | 1 | Read address from master valid |
| s_ar_ready | output | 1 | Read address ready to master |
| s_ar_id | input | ID_W | Read ID |
| s_ar_addr | input | ADDR_W | Read start address |
| s_ar_len | input | 4 | Read beats minus one |
| s_ar_size | input | 3 | Read log2 bytes per beat |
| s_ar_burst | input | 2 | Read burst type |
| s_ar_lock | input | 1 | Read lock |
| s_ar_cache | input | 4 | Read cache attributes |
| s_ar_prot | input | 3 | Read protection attributes |
| m_ar_valid | output | 1 | Read address to memory valid |
| m_ar_ready | input | 1 | Read address ready from memory |
| m_ar_id | output | ID_W | Forwarded read ID |
| m_ar_addr | output | ADDR_W | Forwarded or fault read address |
| m_ar_len | output | 4 | Forwarded read length |
| m_ar_size | output | 3 | Forwarded read size |
| m_ar_burst | output | 2 | Forwarded or forced read burst type |
| m_ar_lock | output | 1 | Forwarded read lock |
| m_ar_cache | output | 4 | Forwarded read cache |
| m_ar_prot | output | 3 | Forwarded read protection |
| aw_viol | output | 1 | Write-channel violation pulse |
| ar_viol | output | 1 | Read-channel violation pulse |
| aw_sticky | output | 1 | Write-channel sticky violation flag |
| ar_sticky | output | 1 | Read-channel sticky violation flag |

## Verification
A beat offered before an edge at which ready is high shows up on the output, together with its violation pulse, one cycle after that edge. The sticky flag follows one cycle later still, and register reads are due in the same cycle the index is applied. The bench drives every input on the falling edge and samples on the falling edge after the accepting rising edge. It reads the status register only after the extra cycle the sticky flag needs. In the back-pressure scenario it holds the output stalled over several falling edges, checks that the first beat stays put and ready stays low, and looks for the second beat one cycle after the stall is released.

// File: rtl/axi_guard_pkg.sv
package axi_guard_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2,
    BURST_RSVD  = 2'd3
  } burst_e;
endpackage

// File: rtl/guard_region_bank.sv
module guard_region_bank #(
  parameter int ADDR_W    = 32,
  parameter int NREG      = 8,
  parameter int GRAN_BITS = 7,
  parameter int CFG_AW    = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [CFG_AW-1:0]                 cfg_addr,
  input  logic [ADDR_W-1:0]                 cfg_wdata,
  output logic [ADDR_W-1:0]                 cfg_rdata,
  input  logic                              aw_viol,
  input  logic                              ar_viol,
  output logic [NREG-1:0][ADDR_W-GRAN_BITS-1:0] start_hi,
  output logic [NREG-1:0][ADDR_W-GRAN_BITS-1:0] end_hi,
  output logic [NREG-1:0]                   win_en,
  output logic                              aw_sticky,
  output logic                              ar_sticky
);
  localparam int HI_W   = ADDR_W - GRAN_BITS;
  localparam int IDX_EN = 2 * NREG;
  localparam int IDX_ST = 2 * NREG + 1;

  logic [NREG-1:0][HI_W-1:0] start_q, end_q;
  logic [NREG-1:0]           en_q;
  logic                      aw_st_q, ar_st_q;
  logic                      clr_sel;

  assign clr_sel = cfg_we && (cfg_addr == CFG_AW'(IDX_ST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      en_q    <= '0;
    end else if (cfg_we) begin
      for (int k = 0; k < NREG; k++) begin
        if (cfg_addr == CFG_AW'(k))        start_q[k] <= cfg_wdata[ADDR_W-1:GRAN_BITS];
        if (cfg_addr == CFG_AW'(NREG + k)) end_q[k]   <= cfg_wdata[ADDR_W-1:GRAN_BITS];
      end
      if (cfg_addr == CFG_AW'(IDX_EN)) en_q <= cfg_wdata[NREG-1:0];
    end
  end

  // New violations take priority over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_st_q <= 1'b0;
      ar_st_q <= 1'b0;
    end else begin
      aw_st_q <= aw_viol | (aw_st_q & ~(clr_sel & cfg_wdata[0]));
      ar_st_q <= ar_viol | (ar_st_q & ~(clr_sel & cfg_wdata[1]));
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int k = 0; k < NREG; k++) begin
      if (cfg_addr == CFG_AW'(k))        cfg_rdata = {start_q[k], {GRAN_BITS{1'b0}}};
      if (cfg_addr == CFG_AW'(NREG + k)) cfg_rdata = {end_q[k], {GRAN_BITS{1'b1}}};
    end
    if (cfg_addr == CFG_AW'(IDX_EN)) cfg_rdata = ADDR_W'(en_q);
    if (cfg_addr == CFG_AW'(IDX_ST)) cfg_rdata = ADDR_W'({ar_st_q, aw_st_q});
  end

  assign start_hi  = start_q;
  assign end_hi    = end_q;
  assign win_en    = en_q;
  assign aw_sticky = aw_st_q;
  assign ar_sticky = ar_st_q;
endmodule

// File: rtl/guard_span.sv
module guard_span
  import axi_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  input  logic [1:0]        burst,
  output logic [ADDR_W-1:0] first,
  output logic [ADDR_W:0]   last,
  output logic              bad
);
  // Largest span: 2^LEN_W beats of 2^(2^SIZE_W - 1) bytes.
  localparam int NB_W = LEN_W + (1 << SIZE_W);
  localparam int AX_W = ADDR_W + 1;

  logic [NB_W-1:0] beats, nbytes, unit;
  logic [AX_W-1:0] addr_x;

  assign beats  = NB_W'(len) + NB_W'(1);
  assign nbytes = beats << size;
  assign unit   = NB_W'(1) << size;
  assign addr_x = {1'b0, addr};

  always_comb begin
    first = addr;
    last  = addr_x + AX_W'(unit) - AX_W'(1);
    bad   = 1'b0;
    case (burst_e'(burst))
      BURST_FIXED: last = addr_x + AX_W'(unit) - AX_W'(1);
      BURST_INCR:  last = addr_x + AX_W'(nbytes) - AX_W'(1);
      BURST_WRAP: begin
        first = addr & ~ADDR_W'(nbytes - NB_W'(1));
        last  = {1'b0, first} + AX_W'(nbytes) - AX_W'(1);
        bad   = ((beats & (beats - NB_W'(1))) != '0) || (beats == NB_W'(1));
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/guard_match.sv
module guard_match #(
  parameter int ADDR_W    = 32,
  parameter int NREG      = 8,
  parameter int GRAN_BITS = 7
) (
  input  logic [ADDR_W-1:0]                     first,
  input  logic [ADDR_W:0]                       last,
  input  logic                                  bad,
  input  logic [NREG-1:0][ADDR_W-GRAN_BITS-1:0] start_hi,
  input  logic [NREG-1:0][ADDR_W-GRAN_BITS-1:0] end_hi,
  input  logic [NREG-1:0]                       win_en,
  output logic                                  legal
);
  logic [NREG-1:0] hit;

  // An inverted window cannot satisfy start <= first <= last <= end.
  // A carry into the top bit of last exceeds every window end.
  for (genvar i = 0; i < NREG; i++) begin : g_win
    assign hit[i] = win_en[i]
                 && ({start_hi[i], {GRAN_BITS{1'b0}}} <= first)
                 && (last <= {1'b0, end_hi[i], {GRAN_BITS{1'b1}}});
  end

  assign legal = (|hit) && !bad;
endmodule

// File: rtl/guard_chan_stage.sv
module guard_chan_stage
  import axi_guard_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              LEN_W      = 4,
  parameter int              SIZE_W     = 3,
  parameter int              SIDE_W     = 12,
  parameter int              NREG       = 8,
  parameter int              GRAN_BITS  = 7,
  parameter logic [ADDR_W-1:0] FAULT_ADDR = '0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  s_valid,
  output logic                                  s_ready,
  input  logic [ADDR_W-1:0]                     s_addr,
  input  logic [LEN_W-1:0]                      s_len,
  input  logic [SIZE_W-1:0]                     s_size,
  input  logic [1:0]                            s_burst,
  input  logic [SIDE_W-1:0]                     s_side,
  output logic                                  m_valid,
  input  logic                                  m_ready,
  output logic [ADDR_W-1:0]                     m_addr,
  output logic [LEN_W-1:0]                      m_len,
  output logic [SIZE_W-1:0]                     m_size,
  output logic [1:0]                            m_burst,
  output logic [SIDE_W-1:0]                     m_side,
  output logic                                  viol,
  input  logic [NREG-1:0][ADDR_W-GRAN_BITS-1:0] start_hi,
  input  logic [NREG-1:0][ADDR_W-GRAN_BITS-1:0] end_hi,
  input  logic [NREG-1:0]                       win_en
);
  logic [ADDR_W-1:0] span_first;
  logic [ADDR_W:0]   span_last;
  logic              span_bad, legal, accept;

  logic              valid_q, viol_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [SIZE_W-1:0] size_q;
  logic [1:0]        burst_q;
  logic [SIDE_W-1:0] side_q;

  guard_span #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_span (
    .addr (s_addr), .len (s_len), .size (s_size), .burst (s_burst),
    .first(span_first), .last(span_last), .bad(span_bad)
  );

  guard_match #(.ADDR_W(ADDR_W), .NREG(NREG), .GRAN_BITS(GRAN_BITS)) u_match (
    .first(span_first), .last(span_last), .bad(span_bad),
    .start_hi(start_hi), .end_hi(end_hi), .win_en(win_en), .legal(legal)
  );

  assign s_ready = !valid_q || m_ready;
  assign accept  = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      viol_q  <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
      size_q  <= '0;
      burst_q <= '0;
      side_q  <= '0;
    end else begin
      viol_q <= accept && !legal;
      if (accept) begin
        valid_q <= 1'b1;
        addr_q  <= legal ? s_addr  : FAULT_ADDR;
        burst_q <= legal ? s_burst : BURST_FIXED;
        len_q   <= s_len;
        size_q  <= s_size;
        side_q  <= s_side;
      end else if (m_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign m_valid = valid_q;
  assign m_addr  = addr_q;
  assign m_len   = len_q;
  assign m_size  = size_q;
  assign m_burst = burst_q;
  assign m_side  = side_q;
  assign viol    = viol_q;
endmodule

// File: rtl/axi_addr_guard.sv
module axi_addr_guard #(
  parameter int                ADDR_W     = 32,
  parameter int                ID_W       = 4,
  parameter int                LEN_W      = 4,
  parameter int                SIZE_W     = 3,
  parameter int                NREG       = 8,
  parameter int                GRAN_BITS  = 7,
  parameter int                CFG_AW     = 5,
  parameter logic [ADDR_W-1:0] FAULT_ADDR = 32'h0000_0F00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              s_aw_valid,
  output logic              s_aw_ready,
  input  logic [ID_W-1:0]   s_aw_id,
  input  logic [ADDR_W-1:0] s_aw_addr,
  input  logic [LEN_W-1:0]  s_aw_len,
  input  logic [SIZE_W-1:0] s_aw_size,
  input  logic [1:0]        s_aw_burst,
  input  logic              s_aw_lock,
  input  logic [3:0]        s_aw_cache,
  input  logic [2:0]        s_aw_prot,
  output logic              m_aw_valid,
  input  logic              m_aw_ready,
  output logic [ID_W-1:0]   m_aw_id,
  output logic [ADDR_W-1:0] m_aw_addr,
  output logic [LEN_W-1:0]  m_aw_len,
  output logic [SIZE_W-1:0] m_aw_size,
  output logic [1:0]        m_aw_burst,
  output logic              m_aw_lock,
  output logic [3:0]        m_aw_cache,
  output logic [2:0]        m_aw_prot,
  input  logic              s_ar_valid,
  output logic              s_ar_ready,
  input  logic [ID_W-1:0]   s_ar_id,
  input  logic [ADDR_W-1:0] s_ar_addr,
  input  logic [LEN_W-1:0]  s_ar_len,
  input  logic [SIZE_W-1:0] s_ar_size,
  input  logic [1:0]        s_ar_burst,
  input  logic              s_ar_lock,
  input  logic [3:0]        s_ar_cache,
  input  logic [2:0]        s_ar_prot,
  output logic              m_ar_valid,
  input  logic              m_ar_ready,
  output logic [ID_W-1:0]   m_ar_id,
  output logic [ADDR_W-1:0] m_ar_addr,
  output logic [LEN_W-1:0]  m_ar_len,
  output logic [SIZE_W-1:0] m_ar_size,
  output logic [1:0]        m_ar_burst,
  output logic              m_ar_lock,
  output logic [3:0]        m_ar_cache,
  output logic [2:0]        m_ar_prot,
  output logic              aw_viol,
  output logic              ar_viol,
  output logic              aw_sticky,
  output logic              ar_sticky
);
  localparam int HI_W   = ADDR_W - GRAN_BITS;
  localparam int SIDE_W = ID_W + 1 + 4 + 3;

  logic [NREG-1:0][HI_W-1:0] start_hi, end_hi;
  logic [NREG-1:0]           win_en;
  logic [SIDE_W-1:0]         aw_side_o, ar_side_o;

  guard_region_bank #(
    .ADDR_W(ADDR_W), .NREG(NREG), .GRAN_BITS(GRAN_BITS), .CFG_AW(CFG_AW)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .aw_viol(aw_viol), .ar_viol(ar_viol),
    .start_hi(start_hi), .end_hi(end_hi), .win_en(win_en),
    .aw_sticky(aw_sticky), .ar_sticky(ar_sticky)
  );

  guard_chan_stage #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .SIDE_W(SIDE_W),
    .NREG(NREG), .GRAN_BITS(GRAN_BITS), .FAULT_ADDR(FAULT_ADDR)
  ) u_aw (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_aw_valid), .s_ready(s_aw_ready), .s_addr(s_aw_addr),
    .s_len(s_aw_len), .s_size(s_aw_size), .s_burst(s_aw_burst),
    .s_side({s_aw_id, s_aw_lock, s_aw_cache, s_aw_prot}),
    .m_valid(m_aw_valid), .m_ready(m_aw_ready), .m_addr(m_aw_addr),
    .m_len(m_aw_len), .m_size(m_aw_size), .m_burst(m_aw_burst), .m_side(aw_side_o),
    .viol(aw_viol), .start_hi(start_hi), .end_hi(end_hi), .win_en(win_en)
  );

  guard_chan_stage #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .SIDE_W(SIDE_W),
    .NREG(NREG), .GRAN_BITS(GRAN_BITS), .FAULT_ADDR(FAULT_ADDR)
  ) u_ar (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_ar_valid), .s_ready(s_ar_ready), .s_addr(s_ar_addr),
    .s_len(s_ar_len), .s_size(s_ar_size), .s_burst(s_ar_burst),
    .s_side({s_ar_id, s_ar_lock, s_ar_cache, s_ar_prot}),
    .m_valid(m_ar_valid), .m_ready(m_ar_ready), .m_addr(m_ar_addr),
    .m_len(m_ar_len), .m_size(m_ar_size), .m_burst(m_ar_burst), .m_side(ar_side_o),
    .viol(ar_viol), .start_hi(start_hi), .end_hi(end_hi), .win_en(win_en)
  );

  assign {m_aw_id, m_aw_lock, m_aw_cache, m_aw_prot} = aw_side_o;
  assign {m_ar_id, m_ar_lock, m_ar_cache, m_ar_prot} = ar_side_o;
endmodule

// File: rtl/axi_addr_guard_chk.sv
module axi_addr_guard_chk #(
  parameter int                ADDR_W     = 32,
  parameter int                LEN_W      = 4,
  parameter logic [ADDR_W-1:0] FAULT_ADDR = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_aw_valid,
  input logic              s_aw_ready,
  input logic [LEN_W-1:0]  s_aw_len,
  input logic              m_aw_valid,
  input logic              m_aw_ready,
  input logic [ADDR_W-1:0] m_aw_addr,
  input logic [1:0]        m_aw_burst,
  input logic [LEN_W-1:0]  m_aw_len,
  input logic              aw_viol,
  input logic              aw_sticky,
  input logic              s_ar_valid,
  input logic              s_ar_ready,
  input logic [LEN_W-1:0]  s_ar_len,
  input logic              m_ar_valid,
  input logic              m_ar_ready,
  input logic [ADDR_W-1:0] m_ar_addr,
  input logic [1:0]        m_ar_burst,
  input logic [LEN_W-1:0]  m_ar_len,
  input logic              ar_viol,
  input logic              ar_sticky
);
  a_r8_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_aw_valid && !m_aw_ready |=> m_aw_valid && $stable(m_aw_addr) && $stable(m_aw_burst));
  a_r8_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_ar_valid && !m_ar_ready |=> m_ar_valid && $stable(m_ar_addr) && $stable(m_ar_burst));
  a_r8_aw_latency: assert property (@(posedge clk) disable iff (!rst_n)
    s_aw_valid && s_aw_ready |=> m_aw_valid);
  a_r8_ar_latency: assert property (@(posedge clk) disable iff (!rst_n)
    s_ar_valid && s_ar_ready |=> m_ar_valid);
  a_r2_aw_len_kept: assert property (@(posedge clk) disable iff (!rst_n)
    s_aw_valid && s_aw_ready |=> m_aw_len == $past(s_aw_len));
  a_r2_ar_len_kept: assert property (@(posedge clk) disable iff (!rst_n)
    s_ar_valid && s_ar_ready |=> m_ar_len == $past(s_ar_len));
  a_r3_aw_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
    aw_viol |-> m_aw_valid && m_aw_burst == 2'd0 && m_aw_addr == FAULT_ADDR);
  a_r3_ar_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
    ar_viol |-> m_ar_valid && m_ar_burst == 2'd0 && m_ar_addr == FAULT_ADDR);
  a_r9_aw_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    aw_viol |-> $past(s_aw_valid && s_aw_ready));
  a_r9_ar_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    ar_viol |-> $past(s_ar_valid && s_ar_ready));
  a_r9_aw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    aw_viol |=> aw_sticky);
  a_r9_ar_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ar_viol |=> ar_sticky);
endmodule

bind axi_addr_guard axi_addr_guard_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FAULT_ADDR(FAULT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_aw_valid(s_aw_valid), .s_aw_ready(s_aw_ready), .s_aw_len(s_aw_len),
  .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready), .m_aw_addr(m_aw_addr),
  .m_aw_burst(m_aw_burst), .m_aw_len(m_aw_len), .aw_viol(aw_viol), .aw_sticky(aw_sticky),
  .s_ar_valid(s_ar_valid), .s_ar_ready(s_ar_ready), .s_ar_len(s_ar_len),
  .m_ar_valid(m_ar_valid), .m_ar_ready(m_ar_ready), .m_ar_addr(m_ar_addr),
  .m_ar_burst(m_ar_burst), .m_ar_len(m_ar_len), .ar_viol(ar_viol), .ar_sticky(ar_sticky)
);

// File: tb/sim_axi_addr_guard.sv
module sim_axi_addr_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FAULT = 32'h0000_0F00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic s_aw_valid = 0, s_ar_valid = 0, m_aw_ready = 1, m_ar_ready = 1;
  logic s_aw_ready, s_ar_ready, m_aw_valid, m_ar_valid;
  logic [3:0] s_aw_id = 0, s_ar_id = 0, s_aw_len = 0, s_ar_len = 0;
  logic [31:0] s_aw_addr = 0, s_ar_addr = 0;
  logic [2:0] s_aw_size = 0, s_ar_size = 0, s_aw_prot = 0, s_ar_prot = 0;
  logic [1:0] s_aw_burst = 0, s_ar_burst = 0;
  logic s_aw_lock = 0, s_ar_lock = 0;
  logic [3:0] s_aw_cache = 0, s_ar_cache = 0;
  logic [3:0] m_aw_id, m_ar_id, m_aw_len, m_ar_len, m_aw_cache, m_ar_cache;
  logic [31:0] m_aw_addr, m_ar_addr;
  logic [2:0] m_aw_size, m_ar_size, m_aw_prot, m_ar_prot;
  logic [1:0] m_aw_burst, m_ar_burst;
  logic m_aw_lock, m_ar_lock;
  logic aw_viol, ar_viol, aw_sticky, ar_sticky;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_addr_guard #(.FAULT_ADDR(FAULT)) u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [4:0] idx, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1; cfg_addr = idx; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_expect(input logic [4:0] idx, input logic [31:0] exp, input string req);
    cfg_addr = idx;
    #1;
    chk(cfg_rdata == exp, req, "register read", cfg_rdata, exp);
  endtask

  // Offer one burst on one channel, check the output beat one cycle later.
  task automatic send(input bit wr, input logic [31:0] a, input logic [3:0] len,
                      input logic [2:0] size, input logic [1:0] bt, input bit ok,
                      input string req);
    logic [31:0] ea;
    logic [1:0]  eb;
    ea = ok ? a : FAULT;
    eb = ok ? bt : 2'd0;
    @(negedge clk);
    if (wr) begin
      s_aw_valid = 1; s_aw_addr = a; s_aw_len = len; s_aw_size = size; s_aw_burst = bt;
      s_aw_id = 4'hA; s_aw_lock = 1; s_aw_cache = 4'h3; s_aw_prot = 3'h2;
    end else begin
      s_ar_valid = 1; s_ar_addr = a; s_ar_len = len; s_ar_size = size; s_ar_burst = bt;
      s_ar_id = 4'h5; s_ar_lock = 1; s_ar_cache = 4'h6; s_ar_prot = 3'h1;
    end
    @(negedge clk);
    s_aw_valid = 0; s_ar_valid = 0;
    if (wr) begin
      chk(m_aw_valid && m_aw_addr == ea && m_aw_burst == eb, req, "aw addr/burst",
          {m_aw_valid, m_aw_burst, m_aw_addr}, {1'b1, eb, ea});
      chk(m_aw_len == len && m_aw_size == size && m_aw_id == 4'hA && m_aw_lock
          && m_aw_cache == 4'h3 && m_aw_prot == 3'h2, req, "aw side fields",
          {m_aw_id, m_aw_len, m_aw_size}, {4'hA, len, size});
      chk(aw_viol == !ok && !ar_viol, req, "aw violation pulse", {ar_viol, aw_viol}, {1'b0, !ok});
    end else begin
      chk(m_ar_valid && m_ar_addr == ea && m_ar_burst == eb, req, "ar addr/burst",
          {m_ar_valid, m_ar_burst, m_ar_addr}, {1'b1, eb, ea});
      chk(m_ar_len == len && m_ar_size == size && m_ar_id == 4'h5 && m_ar_lock
          && m_ar_cache == 4'h6 && m_ar_prot == 3'h1, req, "ar side fields",
          {m_ar_id, m_ar_len, m_ar_size}, {4'h5, len, size});
      chk(ar_viol == !ok && !aw_viol, req, "ar violation pulse", {aw_viol, ar_viol}, {1'b0, !ok});
    end
    @(negedge clk);
  endtask

  task automatic test_reset();
    #1;
    chk(!m_aw_valid && !m_ar_valid, "R8", "outputs empty after reset", {m_aw_valid, m_ar_valid}, 0);
    chk(s_aw_ready && s_ar_ready, "R8", "ready after reset", {s_aw_ready, s_ar_ready}, 2'b11);
    chk(!aw_sticky && !ar_sticky && !aw_viol && !ar_viol, "R9", "flags after reset",
        {aw_sticky, ar_sticky, aw_viol, ar_viol}, 0);
  endtask

  task automatic test_none_enabled();
    send(1, 32'h0000_1000, 0, 2, 2'd1, 0, "R7");
    send(0, 32'h8000_0000, 0, 0, 2'd0, 0, "R7");
  endtask

  task automatic test_registers();
    cfg_write(0, 32'h0000_107F);
    cfg_expect(0, 32'h0000_1000, "R1");
    cfg_write(8, 32'h0000_1F80);
    cfg_expect(8, 32'h0000_1FFF, "R1");
    cfg_write(1, 32'h8000_0000);
    cfg_write(9, 32'h8000_0080);
    cfg_write(2, 32'h0000_5000);
    cfg_write(10, 32'h0000_4000);
    cfg_expect(10, 32'h0000_407F, "R1");
    cfg_write(7, 32'hFFFF_FF80);
    cfg_write(15, 32'hFFFF_FF80);
    cfg_write(16, 32'h0000_0087);
    cfg_expect(16, 32'h0000_0087, "R1");
  endtask

  task automatic test_incr();
    send(1, 32'h0000_1100, 7, 3, 2'd1, 1, "R2");
    send(0, 32'h8000_0010, 3, 2, 2'd1, 1, "R2");
    send(1, 32'h0000_1F80, 15, 3, 2'd1, 1, "R4");
    send(1, 32'h0000_1FF0, 4, 2, 2'd1, 0, "R4");
    send(0, 32'h0000_0F80, 0, 0, 2'd1, 0, "R4");
  endtask

  task automatic test_fixed();
    send(1, 32'h0000_1FFC, 15, 2, 2'd0, 1, "R6");
    send(0, 32'h0000_1FFE, 0, 2, 2'd0, 0, "R6");
  endtask

  task automatic test_wrap();
    send(1, 32'h0000_1FF8, 3, 2, 2'd2, 1, "R5");
    send(1, 32'h0000_1FF8, 3, 2, 2'd1, 0, "R5");
    send(0, 32'h0000_1FF8, 2, 2, 2'd2, 0, "R5");
    send(0, 32'h0000_1100, 0, 2, 2'd3, 0, "R5");
  endtask

  task automatic test_windows();
    send(1, 32'h0000_4800, 0, 0, 2'd1, 0, "R7");
    send(1, 32'h0000_5000, 0, 0, 2'd1, 0, "R7");
    cfg_write(16, 32'h0000_0085);
    send(0, 32'h8000_0010, 0, 2, 2'd1, 0, "R7");
  endtask

  task automatic test_top_of_space();
    send(1, 32'hFFFF_FFC0, 15, 3, 2'd1, 0, "R11");
    send(0, 32'hFFFF_FF80, 15, 3, 2'd1, 1, "R11");
    send(0, 32'hFFFF_FFF0, 0, 2, 2'd0, 1, "R11");
  endtask

  task automatic test_backpressure();
    @(negedge clk);
    m_aw_ready = 0;
    s_aw_valid = 1; s_aw_addr = 32'h0000_1200; s_aw_len = 1; s_aw_size = 2; s_aw_burst = 2'd1;
    @(negedge clk);
    s_aw_addr = 32'h0000_1300; s_aw_len = 2;
    chk(m_aw_valid && m_aw_addr == 32'h0000_1200, "R8", "first beat out",
        {m_aw_valid, m_aw_addr}, {1'b1, 32'h0000_1200});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(m_aw_valid && m_aw_addr == 32'h0000_1200 && m_aw_len == 1 && !s_aw_ready, "R8",
          "stall holds beat", {s_aw_ready, m_aw_valid, m_aw_addr}, {1'b0, 1'b1, 32'h0000_1200});
    end
    m_aw_ready = 1;
    @(negedge clk);
    s_aw_valid = 0;
    chk(m_aw_valid && m_aw_addr == 32'h0000_1300 && m_aw_len == 2, "R8", "second beat after release",
        {m_aw_valid, m_aw_addr}, {1'b1, 32'h0000_1300});
    @(negedge clk);
    chk(!m_aw_valid, "R8", "output drained", m_aw_valid, 0);
  endtask

  task automatic test_independent();
    @(negedge clk);
    s_aw_valid = 1; s_aw_addr = 32'h0000_1000; s_aw_len = 0; s_aw_size = 2; s_aw_burst = 2'd1;
    s_ar_valid = 1; s_ar_addr = 32'h0000_3000; s_ar_len = 0; s_ar_size = 2; s_ar_burst = 2'd1;
    @(negedge clk);
    s_aw_valid = 0; s_ar_valid = 0;
    chk(m_aw_addr == 32'h0000_1000 && m_aw_burst == 2'd1 && !aw_viol, "R10", "write path untouched",
        {aw_viol, m_aw_addr}, {1'b0, 32'h0000_1000});
    chk(m_ar_addr == FAULT && m_ar_burst == 2'd0 && ar_viol, "R10", "read path rewritten",
        {ar_viol, m_ar_addr}, {1'b1, FAULT});
    @(negedge clk);
  endtask

  task automatic test_sticky();
    cfg_write(17, 32'h3);
    cfg_expect(17, 32'h0, "R9");
    send(1, 32'h0000_3000, 0, 0, 2'd1, 0, "R9");
    chk(aw_sticky && !ar_sticky, "R10", "only write sticky set", {ar_sticky, aw_sticky}, 2'b01);
    cfg_expect(17, 32'h1, "R9");
    send(0, 32'h0000_3000, 0, 0, 2'd1, 0, "R9");
    cfg_expect(17, 32'h3, "R9");
    cfg_write(17, 32'h1);
    cfg_expect(17, 32'h2, "R9");
    chk(!aw_sticky && ar_sticky, "R9", "write-one clears only its bit", {ar_sticky, aw_sticky}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_none_enabled();
    test_registers();
    test_incr();
    test_fixed();
    test_wrap();
    test_windows();
    test_top_of_space();
    test_backpressure();
    test_independent();
    test_sticky();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule